// File: doc/BRIEF.md
# Sweep Pattern Table with Write Lockout

This block holds the voltage pattern that a sweep sequencer steps through: a table of 256 words, 16 bits each. Two clients share it. A command-register client fills the table through a write strobe, an address and a data word. The sweep sequencer fetches entries through its own address and read strobe. A single address multiplexer picks which client's address reaches the table, and the sweep-enable level makes that choice.

While the sweep runs, the table is frozen. A write strobe that arrives with sweep enable high leaves every entry unchanged. In the next cycle the block raises a one-cycle reject flag, so the attempt can be seen from outside. Read data is registered. It shows up one clock after the read strobe and holds its value until the next strobe. The contents after power-up are not defined. The client is expected to load the table before it enables the sweep.

Top module: `sweep_table_mem`

## Requirements
- R1: While reset is high, and in the first cycle after it, `rd_data` is 0, `rd_valid` is 0 and `wr_reject` is 0.
- R2: With `sweep_en` low, a cycle with `reg_wr` high stores `wr_data` at entry `reg_addr`.
- R3: With `sweep_en` high, a cycle with `reg_wr` high changes no entry. A later read of that entry returns the value it held before.
- R4: `wr_reject` is high in exactly the cycles that follow a cycle in which `reg_wr` and `sweep_en` were both high. An accepted write never raises it.
- R5: With `sweep_en` high, a cycle with `seq_rd` high loads `rd_data` with the entry at `seq_addr` in the next cycle. `reg_addr` has no effect on the result.
- R6: With `sweep_en` low, a read strobe takes its address from `reg_addr`, and `seq_addr` has no effect on the result.
- R7: `rd_valid` is high in exactly the cycles that follow a cycle with `seq_rd` high.
- R8: `rd_data` keeps its value in every cycle that follows a cycle without a read strobe.
- R9: When a write is accepted and a read is strobed in the same cycle, the read returns the entry's old contents. The new value is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | 16 | Word to store on a register-side write |
| reg_addr | input | 8 | Register-side entry index |
| reg_wr | input | 1 | Register-side write strobe |
| seq_addr | input | 8 | Sequencer-side entry index |
| seq_rd | input | 1 | Read strobe |
| sweep_en | input | 1 | Sweep active: selects the sequencer address and locks out writes |
| rd_data | output | 16 | Registered read word |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| wr_reject | output | 1 | One-cycle pulse after a write attempted during a sweep |

## Verification
Some behaviours are checked on every cycle by the assertions. These are the cause and effect between a blocked write strobe and the reject pulse, between a read strobe and `rd_valid`, and the holding of `rd_data` between strobes. The assertions also check that no write enable ever reaches the storage while the sweep is active. Other behaviours can only be shown by the bench's scenarios, because they concern stored contents over long spans. These are that every one of the 256 entries keeps the right value, that a blocked write leaves its target unchanged, that the unused address has no effect under each setting of sweep enable, and that a same-cycle write and read returns the old word.

// File: rtl/sweep_tbl_pkg.sv
package sweep_tbl_pkg;

    localparam int unsigned TBL_DATA_W = 16;
    localparam int unsigned TBL_DEPTH  = 256;

    // Which client currently drives the table address.
    typedef enum logic {
        SRC_REGS = 1'b0,
        SRC_SEQ  = 1'b1
    } addr_src_e;

    // Registered status that accompanies each table access.
    typedef struct packed {
        logic valid;
        logic reject;
    } tbl_flags_t;

    function automatic addr_src_e pick_source(input logic sweep_on);
        return sweep_on ? SRC_SEQ : SRC_REGS;
    endfunction

endpackage

// File: rtl/sweep_tbl_arbiter.sv
module sweep_tbl_arbiter
    import sweep_tbl_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              sweep_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic              seq_rd,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic              tbl_we,
    output logic              tbl_re,
    output logic              wr_blocked
);

    addr_src_e src;

    always_comb begin
        src = pick_source(sweep_en);
        unique case (src)
            SRC_SEQ:  tbl_addr = seq_addr;
            default:  tbl_addr = reg_addr;
        endcase
        // Write port is locked while the sweep owns the table.
        tbl_we     = reg_wr && (src == SRC_REGS);
        wr_blocked = reg_wr && (src == SRC_SEQ);
        tbl_re     = seq_rd;
    end

endmodule

// File: rtl/sweep_tbl_array.sv
module sweep_tbl_array #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 256,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    // Storage has no reset: contents are loaded by the register client.
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
    end

    // Registered read; a same-cycle write is not yet visible (old word out).
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[addr];
        end
    end

endmodule

// File: rtl/sweep_tbl_flags.sv
module sweep_tbl_flags
    import sweep_tbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_strobe,
    input  logic       wr_blocked,
    output tbl_flags_t flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.valid  <= rd_strobe;
            flags.reject <= wr_blocked;
        end
    end

endmodule

// File: rtl/sweep_table_mem.sv
module sweep_table_mem
    import sweep_tbl_pkg::*;
#(
    parameter int unsigned DATA_W = TBL_DATA_W,
    parameter int unsigned DEPTH  = TBL_DEPTH,
    localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic              seq_rd,
    input  logic              sweep_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              wr_reject
);

    logic [ADDR_W-1:0] tbl_addr;
    logic              tbl_we;
    logic              tbl_re;
    logic              wr_blocked;
    tbl_flags_t        flags;

    sweep_tbl_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .sweep_en   (sweep_en),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .seq_addr   (seq_addr),
        .seq_rd     (seq_rd),
        .tbl_addr   (tbl_addr),
        .tbl_we     (tbl_we),
        .tbl_re     (tbl_re),
        .wr_blocked (wr_blocked)
    );

    sweep_tbl_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst   (rst),
        .addr  (tbl_addr),
        .we    (tbl_we),
        .wdata (wr_data),
        .re    (tbl_re),
        .rdata (rd_data)
    );

    sweep_tbl_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .rd_strobe  (tbl_re),
        .wr_blocked (wr_blocked),
        .flags      (flags)
    );

    assign rd_valid  = flags.valid;
    assign wr_reject = flags.reject;

endmodule

// File: rtl/sweep_table_mem_chk.sv
module sweep_table_mem_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              seq_rd,
    input logic              sweep_en,
    input logic              tbl_we,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              wr_reject
);

    // R3: the storage never sees a write enable while the sweep is on
    p_no_write_in_sweep_r3: assert property (@(posedge clk) disable iff (rst)
        !(tbl_we && sweep_en));

    // R4: a blocked write is followed by the reject pulse
    p_reject_follows_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && sweep_en) |=> wr_reject);

    // R4: the reject pulse has a blocked write as its cause
    p_reject_cause_r4: assert property (@(posedge clk) disable iff (rst)
        wr_reject |-> $past(reg_wr && sweep_en));

    // R7: a read strobe is followed by valid
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
        seq_rd |=> rd_valid);

    // R7: valid has a read strobe as its cause
    p_valid_cause_r7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(seq_rd));

    // R8: read data holds when no strobe was given
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !seq_rd |=> $stable(rd_data));

endmodule

bind sweep_table_mem sweep_table_mem_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .seq_rd    (seq_rd),
    .sweep_en  (sweep_en),
    .tbl_we    (tbl_we),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .wr_reject (wr_reject)
);

// File: tb/tb_sweep_table_mem.sv
`timescale 1ns/1ps
module tb_sweep_table_mem;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] wr_data;
    logic [7:0]  reg_addr;
    logic        reg_wr;
    logic [7:0]  seq_addr;
    logic        seq_rd;
    logic        sweep_en;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        wr_reject;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sweep_table_mem dut (
        .clk(clk), .rst(rst), .wr_data(wr_data), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .seq_addr(seq_addr), .seq_rd(seq_rd),
        .sweep_en(sweep_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_reject(wr_reject)
    );

    function automatic logic [15:0] pat_a(input int a);
        return 16'((a * 40503 + 4660) & 16'hFFFF);
    endfunction

    function automatic logic [15:0] pat_b(input int a);
        return ~pat_a(a) ^ 16'h0F0F;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at a falling edge; return at the next falling edge.
    task automatic cyc(input logic en, input logic wr, input logic rd,
                       input logic [7:0] ra, input logic [7:0] sa, input logic [15:0] wd);
        sweep_en = en; reg_wr = wr; seq_rd = rd;
        reg_addr = ra; seq_addr = sa; wr_data = wd;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        rst = 1'b1;
        sweep_en = 0; reg_wr = 0; seq_rd = 0;
        reg_addr = 0; seq_addr = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        chk("R1 rd_data in reset", 32'(rd_data), 0);
        chk("R1 rd_valid in reset", 32'(rd_valid), 0);
        chk("R1 wr_reject in reset", 32'(wr_reject), 0);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0, 0);
        chk("R1 rd_data after reset", 32'(rd_data), 0);
        chk("R1 rd_valid after reset", 32'(rd_valid), 0);
        chk("R1 wr_reject after reset", 32'(wr_reject), 0);

        // R2: fill the table with sweep off; accepted writes never reject (R4)
        for (int a = 0; a < DEPTH; a++) begin
            cyc(0, 1, 0, 8'(a), 8'(255 - a), pat_a(a));
            chk("R4 no reject on accepted write", 32'(wr_reject), 0);
        end

        // R6 / R2: read back with sweep off, seq_addr pointing elsewhere
        for (int a = 0; a < DEPTH; a++) begin
            cyc(0, 0, 1, 8'(a), 8'(a + 37), 16'h0);
            chk("R6 read via reg_addr", 32'(rd_data), 32'(pat_a(a)));
            chk("R7 valid after strobe", 32'(rd_valid), 1);
        end

        // R8: idle cycles hold data and drop valid
        cyc(0, 0, 0, 8'd3, 8'd4, 16'hFFFF);
        chk("R8 hold after idle", 32'(rd_data), 32'(pat_a(255)));
        chk("R7 valid low when idle", 32'(rd_valid), 0);
        cyc(1, 0, 0, 8'd9, 8'd10, 16'hFFFF);
        chk("R8 hold with sweep on", 32'(rd_data), 32'(pat_a(255)));

        // R3 / R4: blocked writes during the sweep
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1, 1, 0, 8'(a), 8'(a), pat_b(a));
            chk("R4 reject after blocked write", 32'(wr_reject), 1);
            chk("R8 hold across blocked write", 32'(rd_data), 32'(pat_a(255)));
        end
        cyc(1, 0, 0, 0, 0, 0);
        chk("R4 reject is one cycle", 32'(wr_reject), 0);

        // R5 / R3: read all via seq_addr with reg_addr elsewhere
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1, 0, 1, 8'(a ^ 8'h5C), 8'(a), 16'h0);
            chk("R5/R3 sweep read unchanged", 32'(rd_data), 32'(pat_a(a)));
        end

        // R4: blocked write then accepted write in back-to-back cycles
        cyc(1, 1, 0, 8'd20, 8'd0, 16'hDEAD);
        chk("R4 reject pulse", 32'(wr_reject), 1);
        cyc(0, 1, 0, 8'd21, 8'd0, 16'hBEEF);
        chk("R4 no reject for accepted write", 32'(wr_reject), 0);
        cyc(0, 0, 1, 8'd20, 8'd0, 16'h0);
        chk("R3 entry 20 untouched", 32'(rd_data), 32'(pat_a(20)));
        cyc(0, 0, 1, 8'd21, 8'd0, 16'h0);
        chk("R2 entry 21 rewritten", 32'(rd_data), 32'h0000BEEF);

        // R9: same-cycle write and read
        cyc(0, 1, 1, 8'd77, 8'd0, 16'hA5C3);
        chk("R9 old word on collision", 32'(rd_data), 32'(pat_a(77)));
        chk("R7 valid on collision", 32'(rd_valid), 1);
        cyc(0, 0, 1, 8'd77, 8'd200, 16'h0);
        chk("R9 new word on next read", 32'(rd_data), 32'h0000A5C3);

        // R5: sweep-side read sees rewritten entry
        cyc(1, 0, 1, 8'd0, 8'd77, 16'h0);
        chk("R5 sweep read of entry 77", 32'(rd_data), 32'h0000A5C3);

        // R1: reset again clears outputs
        rst = 1'b1;
        cyc(0, 0, 0, 0, 0, 0);
        chk("R1 rd_data cleared by reset", 32'(rd_data), 0);
        chk("R1 rd_valid cleared by reset", 32'(rd_valid), 0);
        rst = 1'b0;

        finish_run();
    end

endmodule